// File: doc/BRIEF.md
# Pulse Density / Pulse Width Modulation Channel

This block drives one output bit from a base clock so that a low-pass load (lamp, speaker, motor driver) sees an average level set by software. Two registers describe the output: a range, which is the length of a repeating cycle counted in base clocks, and a data value, which is how many of those clocks should be high. A mode bit chooses how the high clocks are placed inside the cycle. In width mode they form one solid run at the start of the cycle. In density mode they are single-clock pulses spread as evenly as the cycle allows. Both modes use the same range/data pair.

Software writes the range and the data value through strobed write ports into shadow copies. The channel copies them into its working registers only at the end of a cycle, so a cycle never mixes an old value with a new one. Enable, mode and polarity are written through a third strobed port and act on the next clock. Density placement comes from an accumulator that adds the data value every clock and emits a pulse each time the sum passes the range.

Top module: `pulse_mod_channel`

## Requirements
- R1: The range value sets the cycle length in base clocks. A range of 0 is treated as 1. Range and data writes are captured on a clock edge where their strobe is high.
- R2: In density mode (mode bit = 1), every cycle carries exactly d high clocks. When 2·d ≤ range, every pulse is a single clock wide. Gaps between consecutive pulses differ by at most one clock.
- R3: In width mode (mode bit = 0), the first d clocks of each cycle, counted from enable, are high and the remaining range−d clocks are low. d = 0 gives a constant low and d = range gives a constant high.
- R4: The pattern repeats every cycle for as long as range and data stay unchanged.
- R5: Range and data writes go to shadow registers. A working copy is loaded only at a cycle boundary or while the channel is disabled, so a data write made mid-cycle first shows in the following cycle.
- R6: With the enable bit at 0, the cycle position and the accumulator are held at zero and the output sits at its inactive level: 0, or 1 when inverted. Reset leaves the channel disabled with the output at 0.
- R7: A data value greater than the range behaves as a value equal to the range, which gives a constant high in both modes.
- R8: With the polarity bit at 1, the output is the bitwise complement of the uninverted output.
- R9: The output is registered. The value produced for cycle position p appears one clock after the channel is at position p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for enable, mode and polarity |
| cfg_enable | input | 1 | Channel enable (1 = run) |
| cfg_mode | input | 1 | 0 = width mode, 1 = density mode |
| cfg_invert | input | 1 | 1 = invert output |
| range_we | input | 1 | Write strobe for the range shadow |
| range_val | input | CW | Cycle length in base clocks |
| data_we | input | 1 | Write strobe for the data shadow |
| data_val | input | CW | High clocks per cycle |
| pm_out | output | 1 | Modulated output |

## Verification
The assertions check on every clock that the cycle position and the accumulator stay below the working range. They also check that the working range and data never change in mid-cycle, that the clamped data never exceeds the range, that the position stays at zero while disabled, and that density pulses stay one clock wide when 2·d ≤ range. Other properties only show in the bench scenarios, which look over whole cycles: the exact count of high clocks per cycle, the even spacing of density pulses, a solid run at the start of a width cycle, the one-cycle delay before a mid-cycle data write takes effect, and the output levels under inversion and disable.

// File: rtl/pm_pkg.sv
package pm_pkg;

    typedef enum logic {
        PM_WIDTH   = 1'b0,
        PM_DENSITY = 1'b1
    } pm_mode_e;

    typedef struct packed {
        logic     enable;
        pm_mode_e mode;
        logic     invert;
    } pm_ctrl_t;

    // Cycle length never drops below one clock
    function automatic logic [31:0] pm_fix_range(input logic [31:0] r);
        return (r == 32'd0) ? 32'd1 : r;
    endfunction

    // High count is capped at the cycle length
    function automatic logic [31:0] pm_fix_data(input logic [31:0] d, input logic [31:0] r);
        return (d > r) ? r : d;
    endfunction

endpackage

// File: rtl/pm_cycle_timer.sv
module pm_cycle_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [CW-1:0] tc,
    output logic [CW-1:0] pos,
    output logic          last
);

    assign last = run && (pos == tc - CW'(1));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pos <= '0;
        end else if (last) begin
            pos <= '0;
        end else begin
            pos <= pos + CW'(1);
        end
    end

    // R1: position stays inside the working cycle
    a_r1_pos_in_range: assert property (@(posedge clk) disable iff (rst)
        run |-> (pos < tc));

    // R6: a disabled channel holds its position at zero
    a_r6_idle_clears_pos: assert property (@(posedge clk) disable iff (rst)
        !run |=> (pos == '0));

endmodule

// File: rtl/pm_density_acc.sv
module pm_density_acc #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          last,
    input  logic [CW-1:0] tc,
    input  logic [CW-1:0] d,
    output logic          pulse
);

    logic [CW-1:0] acc;
    logic [CW:0]   sum;

    assign sum   = {1'b0, acc} + {1'b0, d};
    assign pulse = run && (sum >= {1'b0, tc});

    always_ff @(posedge clk) begin
        if (rst || !run || last) begin
            acc <= '0;
        end else if (pulse) begin
            acc <= CW'(sum - {1'b0, tc});
        end else begin
            acc <= sum[CW-1:0];
        end
    end

    // R2: accumulator remainder is always below the cycle length
    a_r2_acc_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> (acc < tc));

    // R2: sparse densities give single-clock pulses
    a_r2_single_clock: assert property (@(posedge clk) disable iff (rst)
        (pulse && !last && ({d, 1'b0} <= {1'b0, tc})) |=> !pulse);

endmodule

// File: rtl/pm_width_cmp.sv
module pm_width_cmp #(
    parameter int CW = 16
) (
    input  logic [CW-1:0] pos,
    input  logic [CW-1:0] d,
    input  logic          run,
    output logic          high
);

    assign high = run && (pos < d);

endmodule

// File: rtl/pulse_mod_channel.sv
module pulse_mod_channel
    import pm_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic          cfg_enable,
    input  logic          cfg_mode,
    input  logic          cfg_invert,
    input  logic          range_we,
    input  logic [CW-1:0] range_val,
    input  logic          data_we,
    input  logic [CW-1:0] data_val,
    output logic          pm_out
);

    pm_ctrl_t      ctrl;
    logic [CW-1:0] range_sh;
    logic [CW-1:0] data_sh;
    logic [CW-1:0] tc_act;
    logic [CW-1:0] d_act;
    logic [CW-1:0] tc_next;
    logic [CW-1:0] d_next;
    logic [CW-1:0] pos;
    logic          last;
    logic          dens_pulse;
    logic          width_high;
    logic          raw;
    logic          load_act;
    logic          out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '{enable: 1'b0, mode: PM_WIDTH, invert: 1'b0};
            range_sh <= CW'(1);
            data_sh  <= '0;
        end else begin
            if (cfg_we) begin
                ctrl <= '{enable: cfg_enable, mode: pm_mode_e'(cfg_mode), invert: cfg_invert};
            end
            if (range_we) range_sh <= range_val;
            if (data_we)  data_sh  <= data_val;
        end
    end

    assign tc_next  = CW'(pm_fix_range(32'(range_sh)));
    assign d_next   = CW'(pm_fix_data(32'(data_sh), 32'(tc_next)));
    assign load_act = !ctrl.enable || last;

    always_ff @(posedge clk) begin
        if (rst) begin
            tc_act <= CW'(1);
            d_act  <= '0;
        end else if (load_act) begin
            tc_act <= tc_next;
            d_act  <= d_next;
        end
    end

    pm_cycle_timer #(.CW(CW)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (ctrl.enable),
        .tc   (tc_act),
        .pos  (pos),
        .last (last)
    );

    pm_density_acc #(.CW(CW)) u_density (
        .clk   (clk),
        .rst   (rst),
        .run   (ctrl.enable),
        .last  (last),
        .tc    (tc_act),
        .d     (d_act),
        .pulse (dens_pulse)
    );

    pm_width_cmp #(.CW(CW)) u_width (
        .pos  (pos),
        .d    (d_act),
        .run  (ctrl.enable),
        .high (width_high)
    );

    assign raw = (ctrl.mode == PM_DENSITY) ? dens_pulse : width_high;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= 1'b0;
        end else begin
            out_q <= (ctrl.enable && raw) ^ ctrl.invert;
        end
    end

    assign pm_out = out_q;

    // R5: working range and data only change at a boundary or while idle
    a_r5_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        (ctrl.enable && !last) |=> ($stable(d_act) && $stable(tc_act)));

    // R7: clamped data never exceeds the working range, range never zero
    a_r7_data_clamped: assert property (@(posedge clk) disable iff (rst)
        (d_act <= tc_act) && (tc_act != '0));

endmodule

// File: tb/tb_pulse_mod_channel.sv
module tb_pulse_mod_channel;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          cfg_we, cfg_enable, cfg_mode, cfg_invert;
    logic          range_we, data_we;
    logic [CW-1:0] range_val, data_val;
    logic          pm_out;

    int  n_tests = 0;
    int  n_fail  = 0;
    logic samp [0:255];

    always #4 clk = ~clk;

    pulse_mod_channel #(.CW(CW)) dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode), .cfg_invert(cfg_invert),
        .range_we(range_we), .range_val(range_val),
        .data_we(data_we), .data_val(data_val),
        .pm_out(pm_out)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input bit en, input bit mode, input bit inv);
        cfg_enable = en; cfg_mode = mode; cfg_invert = inv; cfg_we = 1'b1;
        tick();
        cfg_we = 1'b0;
    endtask

    // Disable, load range/data, then enable: sample 0 reflects position 0
    task automatic setup(input int tc, input int d, input bit mode, input bit inv);
        set_cfg(1'b0, mode, inv);
        range_val = CW'(tc); data_val = CW'(d);
        range_we = 1'b1; data_we = 1'b1;
        tick();
        range_we = 1'b0; data_we = 1'b0;
        set_cfg(1'b1, mode, inv);
    endtask

    task automatic collect(input int n);
        for (int i = 0; i < n; i++) begin
            tick();
            samp[i] = pm_out;
        end
    endtask

    function automatic int ones(input int start, input int len);
        int c = 0;
        for (int i = start; i < start + len; i++) c += samp[i] ? 1 : 0;
        return c;
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        cfg_we = 0; cfg_enable = 0; cfg_mode = 0; cfg_invert = 0;
        range_we = 0; data_we = 0; range_val = '0; data_val = '0;
        repeat (3) tick();
        check(pm_out == 1'b0, "R6 reset output", int'(pm_out), 0);
        rst = 1'b0;
        tick();
        check(pm_out == 1'b0, "R6 idle after reset", int'(pm_out), 0);
    endtask

    task automatic t_width_and_shadow();
        int first_run;
        setup(10, 3, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) begin
            if (i == 4) begin data_val = CW'(7); data_we = 1'b1; end
            tick();
            data_we = 1'b0;
            samp[i] = pm_out;
        end
        check(ones(0, 10) == 3, "R3 width count tc10 d3", ones(0, 10), 3);
        first_run = ones(0, 3);
        check(first_run == 3, "R3 width run at cycle start", first_run, 3);
        check(ones(10, 10) == 7, "R5 mid-cycle write shows next cycle", ones(10, 10), 7);
        check(ones(10, 7) == 7, "R9 new run starts at sample 10", ones(10, 7), 7);
    endtask

    task automatic t_width_edges();
        setup(12, 0, 1'b0, 1'b0);
        collect(24);
        check(ones(0, 24) == 0, "R3 width d0 constant low", ones(0, 24), 0);
        setup(12, 12, 1'b0, 1'b0);
        collect(24);
        check(ones(0, 24) == 24, "R3 width d=tc constant high", ones(0, 24), 24);
    endtask

    task automatic t_density(input int tc, input int d);
        int last_p, gmin, gmax, adj;
        setup(tc, d, 1'b1, 1'b0);
        collect(2 * tc);
        check(ones(0, tc) == d, "R2 density count first cycle", ones(0, tc), d);
        check(ones(tc, tc) == d, "R4 density count repeats", ones(tc, tc), d);
        last_p = -1; gmin = 1 << 20; gmax = 0; adj = 0;
        for (int i = 0; i < 2 * tc; i++) begin
            if (samp[i]) begin
                if (last_p >= 0) begin
                    if (i - last_p < gmin) gmin = i - last_p;
                    if (i - last_p > gmax) gmax = i - last_p;
                    if (i - last_p == 1) adj++;
                end
                last_p = i;
            end
        end
        if (d >= 2) check(gmax - gmin <= 1, "R2 density even spacing", gmax - gmin, 1);
        if (2 * d <= tc) check(adj == 0, "R2 density single-clock pulses", adj, 0);
    endtask

    task automatic t_density_edges();
        setup(9, 9, 1'b1, 1'b0);
        collect(18);
        check(ones(0, 18) == 18, "R2 density d=tc constant high", ones(0, 18), 18);
        setup(9, 0, 1'b1, 1'b0);
        collect(18);
        check(ones(0, 18) == 0, "R2 density d0 constant low", ones(0, 18), 0);
    endtask

    task automatic t_clamp();
        setup(10, 15, 1'b0, 1'b0);
        collect(20);
        check(ones(0, 20) == 20, "R7 width data>range high", ones(0, 20), 20);
        setup(10, 15, 1'b1, 1'b0);
        collect(20);
        check(ones(0, 20) == 20, "R7 density data>range high", ones(0, 20), 20);
        setup(0, 1, 1'b0, 1'b0);
        collect(8);
        check(ones(0, 8) == 8, "R1 range zero acts as one", ones(0, 8), 8);
    endtask

    task automatic t_polarity_disable();
        setup(10, 3, 1'b0, 1'b1);
        collect(10);
        check(ones(0, 10) == 7, "R8 inverted width count", ones(0, 10), 7);
        check(ones(0, 3) == 0, "R8 inverted run is low", ones(0, 3), 0);
        set_cfg(1'b0, 1'b0, 1'b1);
        collect(10);
        check(ones(1, 9) == 9, "R6 disabled inverted idles high", ones(1, 9), 9);
        set_cfg(1'b0, 1'b1, 1'b0);
        collect(10);
        check(ones(1, 9) == 0, "R6 disabled idles low", ones(1, 9), 0);
    endtask

    initial begin
        t_reset();
        t_width_and_shadow();
        t_width_edges();
        t_density(10, 3);
        t_density(16, 5);
        t_density(20, 13);
        t_density_edges();
        t_clamp();
        t_polarity_disable();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #800000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule